// File: doc/BRIEF.md
# LCD Vertical Timing Generator

This block produces the frame-level vertical timing for an LCD controller. It counts in units of line clocks. A one-cycle line enable marks each line clock, and a strobe marks the end of the last visible line of a frame. When that strobe arrives, the block enters vertical blanking. Blanking is made of up to three phases, taken in a fixed order: front porch, sync, back porch. When the last phase ends, the block issues a one-cycle start-of-frame strobe and drops the blanking flag.

The panel mode bit selects how the sync field is used:

- **Active-panel mode:** the sync output is high for a pulse of sync-field-plus-one line clocks. The pulse sits between the front-porch and back-porch counts.
- **Passive-panel mode:** the sync field adds dummy line periods to blanking, the same way the two porch fields do. The sync pin does not follow the sync field. Instead it has a fixed shape: it is high from the start-of-frame strobe until the next line clock.

The three fields and the mode bit are captured on the end-of-frame strobe. Software may therefore rewrite them at any time, and a change applies from the next frame.

Top module: `lcd_vtiming`

## Requirements
- R1: After synchronous reset, the block is in the display state: `blanking`=0, `vsync`=0 and `frame_start`=0.
- R2: `frame_last` sampled high while `blanking`=0 starts blanking, seen from the next cycle. `frame_last` while `blanking`=1 is ignored. `line_tick` while `blanking`=0 has no effect.
- R3: Active mode (`panel_active`=1): `vsync` rises after exactly `front_lines` line ticks of blanking. When `front_lines`=0, `vsync` is high from the first blanking cycle. `vsync` is high only while `blanking`=1.
- R4: Active mode: `vsync` stays high for `sync_lines`+1 line ticks, so the width is 1 to 64 line clocks with the 6-bit field.
- R5: Active mode: after `vsync` falls, `back_lines` line ticks pass. Then `blanking` falls. When `back_lines`=0, `blanking` falls on the same tick that ends the sync pulse.
- R6: Passive mode (`panel_active`=0): blanking lasts `front_lines`+`sync_lines`+`back_lines` line ticks, so any split of the same total gives identical timing. A zero field uses no line tick. When all three fields are 0, `frame_start` pulses in the cycle after `frame_last`.
- R7: Passive mode: `vsync` is 0 throughout blanking, whatever the value of `sync_lines`. It is 1 from the `frame_start` cycle up to and including the next `line_tick` cycle, and 0 after it.
- R8: The blanking counters advance only on `line_tick`. Cycles without a tick leave `blanking` and `vsync` unchanged.
- R9: The mode and the three fields are captured in the `frame_last` cycle that starts blanking. Input changes during blanking do not alter the current frame's timing, but do apply at the next frame.
- R10: `frame_start` is a single-cycle pulse. It is high exactly in the first cycle with `blanking`=0 after blanking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| line_tick | input | 1 | One-cycle line clock enable |
| frame_last | input | 1 | Strobe: last visible line of the frame has been sent |
| panel_active | input | 1 | 1 = active panel (sync pulse), 0 = passive panel (dummy lines) |
| front_lines | input | FP_W | Front-porch line count |
| sync_lines | input | SW_W | Active: sync width minus one; passive: extra dummy lines |
| back_lines | input | BP_W | Back-porch line count |
| vsync | output | 1 | Vertical sync |
| blanking | output | 1 | High during vertical blanking |
| frame_start | output | 1 | One-cycle strobe at the first line of a new frame |

## Verification
The bench steps through every blanking line of each frame and checks the sync and blanking outputs after every tick. It also checks them again after idle cycles, so a design that counted clock cycles instead of line ticks would drift.

Zero-length fields get their own frames:
- a zero front porch must raise sync on the very first blanking line;
- a zero back porch must end blanking on the tick that ends sync;
- an all-zero passive setting must produce the frame strobe in the very next cycle. An off-by-one skip would add a dead line in any of these cases.

The maximum 64-line sync pulse exposes a width that was computed from the field value instead of the field value plus one. Three different passive splits of the same total must produce identical frames, which catches fields consumed in the wrong way.

A rewrite of the fields during blanking, together with a stray end-of-frame strobe, shows whether configuration is sampled at the wrong time or blanking is restarted.

// File: rtl/lcd_vt_pkg.sv
package lcd_vt_pkg;

  // Blanking phases in the order they are taken; the numeric order is the
  // search order used to skip zero-length phases.
  typedef enum logic [1:0] {
    PH_DISP  = 2'd0,
    PH_FRONT = 2'd1,
    PH_SYNC  = 2'd2,
    PH_BACK  = 2'd3
  } vphase_e;

  localparam int NUM_PH = 4;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/lcd_vt_cfg.sv
module lcd_vt_cfg #(
  parameter int FP_W = 8,
  parameter int SW_W = 6,
  parameter int BP_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take,
  input  logic            tft_in,
  input  logic [FP_W-1:0] fp_in,
  input  logic [SW_W-1:0] sw_in,
  input  logic [BP_W-1:0] bp_in,
  output logic            tft_eff,
  output logic [FP_W-1:0] fp_eff,
  output logic [SW_W-1:0] sw_eff,
  output logic [BP_W-1:0] bp_eff
);

  logic            tft_q;
  logic [FP_W-1:0] fp_q;
  logic [SW_W-1:0] sw_q;
  logic [BP_W-1:0] bp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tft_q <= 1'b0;
      fp_q  <= '0;
      sw_q  <= '0;
      bp_q  <= '0;
    end else if (take) begin
      tft_q <= tft_in;
      fp_q  <= fp_in;
      sw_q  <= sw_in;
      bp_q  <= bp_in;
    end
  end

  // In the capture cycle the new values already steer the first phase choice.
  always_comb begin
    tft_eff = take ? tft_in : tft_q;
    fp_eff  = take ? fp_in  : fp_q;
    sw_eff  = take ? sw_in  : sw_q;
    bp_eff  = take ? bp_in  : bp_q;
  end

  // R9: held configuration changes only in a capture cycle
  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !take |=> ($stable(fp_q) && $stable(sw_q) && $stable(bp_q) && $stable(tft_q)))
    else $error("p_cfg_hold_r9");

endmodule

// File: rtl/lcd_vt_seq.sv
module lcd_vt_seq
  import lcd_vt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_en,
  input  logic             start,
  input  logic             tft,
  input  logic [CNT_W-1:0] fp,
  input  logic [CNT_W-1:0] sw,
  input  logic [CNT_W-1:0] bp,
  output vphase_e          ph,
  output logic             sof
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] load;
  logic [CNT_W:0]   len [NUM_PH];
  vphase_e          nxt;
  logic             advance;

  // Length in line clocks of each phase under the captured mode.
  always_comb begin
    len[0] = '0;
    len[1] = {1'b0, fp};
    len[2] = tft ? ({1'b0, sw} + 1'b1) : {1'b0, sw};
    len[3] = {1'b0, bp};
  end

  // First non-empty phase after the current one; display if none remain.
  always_comb begin
    nxt  = PH_DISP;
    load = '0;
    for (int i = NUM_PH - 1; i > 0; i--) begin
      if (i > int'(ph) && len[i] != '0) begin
        nxt  = vphase_e'(2'(i));
        load = CNT_W'(len[i] - 1'b1);
      end
    end
  end

  assign advance = (ph == PH_DISP) ? start : (line_en && cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph  <= PH_DISP;
      cnt <= '0;
      sof <= 1'b0;
    end else begin
      sof <= 1'b0;
      if (advance) begin
        ph  <= nxt;
        cnt <= load;
        sof <= (nxt == PH_DISP);
      end else if (ph != PH_DISP && line_en) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  // R8: without a line clock, blanking state is frozen
  p_hold_no_tick_r8: assert property (@(posedge clk) disable iff (rst)
    (ph != PH_DISP && !line_en) |=> ($stable(ph) && $stable(cnt)))
    else $error("p_hold_no_tick_r8");

  // R4: the active sync down counter never exceeds the captured width field
  p_sync_bound_r4: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_SYNC && tft) |-> (cnt <= sw))
    else $error("p_sync_bound_r4");

  // R2: display persists until the end-of-frame strobe
  p_disp_stays_r2: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_DISP && !start) |=> (ph == PH_DISP))
    else $error("p_disp_stays_r2");

endmodule

// File: rtl/lcd_vt_out.sv
module lcd_vt_out
  import lcd_vt_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    line_en,
  input  logic    start,
  input  logic    tft,
  input  vphase_e ph,
  input  logic    sof,
  output logic    vsync
);

  logic pv_q;

  // Passive first-line marker: held from the frame strobe to the next tick.
  always_ff @(posedge clk) begin
    if (rst || line_en || start) pv_q <= 1'b0;
    else if (sof)                pv_q <= 1'b1;
  end

  assign vsync = tft ? (ph == PH_SYNC) : (sof | pv_q);

  // R7: passive sync stays low throughout blanking
  p_pass_vs_low_r7: assert property (@(posedge clk) disable iff (rst)
    (!tft && ph != PH_DISP) |-> !vsync)
    else $error("p_pass_vs_low_r7");

endmodule

// File: rtl/lcd_vtiming.sv
module lcd_vtiming
  import lcd_vt_pkg::*;
#(
  parameter int FP_W = 8,
  parameter int SW_W = 6,
  parameter int BP_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            line_tick,
  input  logic            frame_last,
  input  logic            panel_active,
  input  logic [FP_W-1:0] front_lines,
  input  logic [SW_W-1:0] sync_lines,
  input  logic [BP_W-1:0] back_lines,
  output logic            vsync,
  output logic            blanking,
  output logic            frame_start
);

  localparam int CNT_W = max3(FP_W, SW_W, BP_W);

  vphase_e         ph;
  logic            take;
  logic            tft_eff;
  logic [FP_W-1:0] fp_eff;
  logic [SW_W-1:0] sw_eff;
  logic [BP_W-1:0] bp_eff;

  assign take = frame_last && (ph == PH_DISP);

  lcd_vt_cfg #(.FP_W(FP_W), .SW_W(SW_W), .BP_W(BP_W)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .take    (take),
    .tft_in  (panel_active),
    .fp_in   (front_lines),
    .sw_in   (sync_lines),
    .bp_in   (back_lines),
    .tft_eff (tft_eff),
    .fp_eff  (fp_eff),
    .sw_eff  (sw_eff),
    .bp_eff  (bp_eff)
  );

  lcd_vt_seq #(.CNT_W(CNT_W)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .line_en (line_tick),
    .start   (take),
    .tft     (tft_eff),
    .fp      (CNT_W'(fp_eff)),
    .sw      (CNT_W'(sw_eff)),
    .bp      (CNT_W'(bp_eff)),
    .ph      (ph),
    .sof     (frame_start)
  );

  lcd_vt_out u_out (
    .clk     (clk),
    .rst     (rst),
    .line_en (line_tick),
    .start   (take),
    .tft     (tft_eff),
    .ph      (ph),
    .sof     (frame_start),
    .vsync   (vsync)
  );

  assign blanking = (ph != PH_DISP);

  // R10: the frame strobe marks the end of blanking and never occurs inside it
  p_sof_ends_blank_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(blanking) |-> frame_start)
    else $error("p_sof_ends_blank_r10");

  p_sof_not_blank_r10: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> !blanking)
    else $error("p_sof_not_blank_r10");

  // R3: active-mode sync only inside blanking
  p_act_vs_in_blank_r3: assert property (@(posedge clk) disable iff (rst)
    (tft_eff && vsync) |-> blanking)
    else $error("p_act_vs_in_blank_r3");

endmodule

// File: tb/tb_lcd_vtiming.sv
module tb_lcd_vtiming;

  logic       clk = 1'b0;
  logic       rst;
  logic       line_tick;
  logic       frame_last;
  logic       panel_active;
  logic [7:0] front_lines;
  logic [5:0] sync_lines;
  logic [7:0] back_lines;
  logic       vsync;
  logic       blanking;
  logic       frame_start;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  lcd_vtiming dut (
    .clk          (clk),
    .rst          (rst),
    .line_tick    (line_tick),
    .frame_last   (frame_last),
    .panel_active (panel_active),
    .front_lines  (front_lines),
    .sync_lines   (sync_lines),
    .back_lines   (back_lines),
    .vsync        (vsync),
    .blanking     (blanking),
    .frame_start  (frame_start)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_line(input bit also_last);
    line_tick  = 1'b1;
    frame_last = also_last;
    @(posedge clk);
    @(negedge clk);
    line_tick  = 1'b0;
    frame_last = 1'b0;
  endtask

  // One full blanking interval, line by line, then the new-frame checks.
  task automatic run_frame(input string req, input bit m, input int f, input int s,
                           input int b, input bit disturb);
    int total;
    int exp_vs;
    total = m ? (f + s + 1 + b) : (f + s + b);
    panel_active = m;
    front_lines  = 8'(f);
    sync_lines   = 6'(s);
    back_lines   = 8'(b);
    frame_last   = 1'b1;
    @(posedge clk);
    @(negedge clk);
    frame_last = 1'b0;
    if (disturb) begin
      // R9: these must not affect the frame in progress
      panel_active = ~m;
      front_lines  = 8'd9;
      sync_lines   = 6'd0;
      back_lines   = 8'd7;
    end
    for (int k = 0; k < total; k++) begin
      if (k > 0) pulse_line(disturb && k == 1); // R2: stray strobe in blanking
      exp_vs = (m && k >= f && k < f + s + 1) ? 1 : 0;
      chk(req, $sformatf("blanking line %0d", k), int'(blanking), 1);
      chk(req, $sformatf("vsync line %0d", k), int'(vsync), exp_vs);
      idle(2);
      chk("R8", $sformatf("blanking held line %0d", k), int'(blanking), 1);
      chk("R8", $sformatf("vsync held line %0d", k), int'(vsync), exp_vs);
    end
    if (total > 0) pulse_line(1'b0);
    chk(req, "blanking ended", int'(blanking), 0);
    chk("R10", "frame_start at end", int'(frame_start), 1);
    chk("R7", "vsync at frame_start", int'(vsync), m ? 0 : 1);
    idle(1);
    chk("R10", "frame_start single cycle", int'(frame_start), 0);
    if (!m) begin
      chk("R7", "passive vsync held to tick", int'(vsync), 1);
      pulse_line(1'b0);
      chk("R7", "passive vsync after tick", int'(vsync), 0);
    end
    chk("R2", "display after tick", int'(blanking), 0);
  endtask

  task automatic test_reset();
    rst = 1'b1;
    idle(3);
    rst = 1'b0;
    chk("R1", "blanking after reset", int'(blanking), 0);
    chk("R1", "vsync after reset", int'(vsync), 0);
    chk("R1", "frame_start after reset", int'(frame_start), 0);
    pulse_line(1'b0);
    chk("R2", "tick in display keeps display", int'(blanking), 0);
    chk("R2", "tick in display no strobe", int'(frame_start), 0);
  endtask

  task automatic test_active();
    run_frame("R3", 1'b1, 2, 1, 1, 1'b0);
    run_frame("R3", 1'b1, 0, 2, 3, 1'b0);   // zero front porch
    run_frame("R4", 1'b1, 1, 63, 0, 1'b0);  // 64-line sync, zero back porch
    run_frame("R4", 1'b1, 0, 0, 0, 1'b0);   // 1-line sync
    run_frame("R5", 1'b1, 1, 0, 4, 1'b0);
  endtask

  task automatic test_passive();
    run_frame("R6", 1'b0, 3, 0, 2, 1'b0);
    run_frame("R6", 1'b0, 0, 5, 0, 1'b0);
    run_frame("R6", 1'b0, 1, 2, 2, 1'b0);
    run_frame("R6", 1'b0, 0, 0, 0, 1'b0);   // strobe right after frame_last
    run_frame("R7", 1'b0, 2, 9, 1, 1'b0);
  endtask

  task automatic test_capture();
    run_frame("R9", 1'b1, 2, 1, 1, 1'b1);
    run_frame("R9", 1'b0, 1, 1, 1, 1'b0);
  endtask

  initial begin
    rst          = 1'b1;
    line_tick    = 1'b0;
    frame_last   = 1'b0;
    panel_active = 1'b0;
    front_lines  = '0;
    sync_lines   = '0;
    back_lines   = '0;
    @(negedge clk);
    test_reset();
    test_active();
    test_passive();
    test_capture();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule